// File: doc/BRIEF.md
# Mode-Aware Four-Pin GPIO Port

This block is a four-pin general-purpose I/O port on an 8-bit register bus with a 16-bit address. Software sets each pin's direction, output level, pull-up and open-drain behaviour through five registers, and reads back the synchronized pin levels. The block drives per-pin output-enable, output-value and pull-up-enable signals to external pad cells. Only bits 3..0 of each register are used. Bits 7..4 are reserved.

An operating-mode input can give all four pins to an external address bus. In that case the pins drive address bits whatever the direction register holds. The block has two standby inputs. Hardware standby clears the configuration and releases the pads. Software standby keeps the configuration. For pins in address mode, an output-hold input then decides whether those pins keep their last address value or float.

There are two reset inputs. The power-on reset clears everything. The manual reset clears the data, pull-up and open-drain registers but leaves the direction register as it was.

Top module: `gpio4_port`

## Requirements
- R1: When the power-on reset `rst` is asserted, it clears all registers and the two synchronizer stages. After it, every pad has output-enable 0, output 0 and pull-up 0.
- R2: A read of the direction address returns the fixed value 0xFF. Reads of the other registers return 0 in bits 7..4. When `bus_rd` is low, `bus_rdata` is 0, and a read of an unmapped address also returns 0.
- R3: Outside the address modes, a direction bit of 1 makes the pin drive its data bit with output-enable 1. A direction bit of 0 gives output-enable 0 and output 0.
- R4: `hw_stby` clears the direction register, and so does the power-on reset. `manual_rst` and `sw_stby` leave the direction register unchanged. `manual_rst` clears the data, pull-up and open-drain registers and ignores any bus write made in the same cycle.
- R5: The data (0xFF69), pull-up (0xFF70) and open-drain (0xFF77) registers are read/write on bits 3..0. A write takes effect at the clock edge that samples it.
- R6: A read of 0xFF59 returns `pin_in` as sampled two clock edges earlier, in bits 3..0. A write to 0xFF59 changes no register.
- R7: When `op_mode` is 4 or 5, every pin drives `addr_in` with output-enable 1 and pull-up 0, whatever the direction bits hold. This applies while not in standby.
- R8: In software standby with `op_mode` 4 or 5 and `out_hold` set, the pins drive the `addr_in` value sampled at the last edge before standby. With `out_hold` clear, those pins have output-enable 0 and output 0.
- R9: A pin's pull-up enable is 1 only when its direction bit is 0, its pull-up bit is 1, the port is not in an address mode and `hw_stby` is low.
- R10: A GPIO output pin whose open-drain bit is 1 has output-enable 0 while its data bit is 1, and drives 0 while its data bit is 0.
- R11: While `hw_stby` is high, all pads are released (output-enable, output and pull-up all 0) and bus writes are ignored.
- R12: The direction register is written at address 0xFEB9, bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| manual_rst | input | 1 | Manual reset; keeps direction |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| out_hold | input | 1 | Hold address outputs during software standby |
| op_mode | input | 3 | Operating mode |
| addr_in | input | 4 | Address bits offered to the pins in address modes |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 4 | Pad input levels |
| pad_oe | output | 4 | Pad output enables |
| pad_out | output | 4 | Pad output values |
| pad_pu | output | 4 | Pad pull-up enables |

## Verification
The direction register cannot be read back, so a wrong direction bit can only be seen at the pads. It shows in `pad_oe` and `pad_pu` in the same cycle as the fault, whenever the port is outside the address modes. It stays hidden during address modes and standby.

A wrong hold register shows in `pad_out` only during software standby with hold enabled. A synchronizer fault shows at the second edge after a pin change, in a read of the pin address.

The reference model is compared against every output on every cycle. Because of that, a state error shows up within one cycle of the first stimulus that exposes it.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
    localparam int NPIN = 4;
    localparam int DW   = 8;
    localparam int AW   = 16;

    localparam logic [AW-1:0] ADR_DIR = 16'hFEB9;
    localparam logic [AW-1:0] ADR_DAT = 16'hFF69;
    localparam logic [AW-1:0] ADR_PIN = 16'hFF59;
    localparam logic [AW-1:0] ADR_PU  = 16'hFF70;
    localparam logic [AW-1:0] ADR_OD  = 16'hFF77;

    localparam logic [DW-1:0] DIR_READ_FILL = 8'hFF;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_DIR, SEL_DAT, SEL_PIN, SEL_PU, SEL_OD
    } reg_sel_e;

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dat;
        logic [NPIN-1:0] pu;
        logic [NPIN-1:0] od;
    } port_cfg_t;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        case (a)
            ADR_DIR: return SEL_DIR;
            ADR_DAT: return SEL_DAT;
            ADR_PIN: return SEL_PIN;
            ADR_PU:  return SEL_PU;
            ADR_OD:  return SEL_OD;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_addr_mode(input logic [2:0] m);
        return (m == 3'd4) || (m == 3'd5);
    endfunction

    function automatic logic [DW-1:0] zext(input logic [NPIN-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[NPIN-1:0] = v;
        return r;
    endfunction
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

    assert_two_stage_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> s2_q == $past(s1_q));
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
    import gpio4_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            manual_rst,
    input  logic            hw_stby,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NPIN-1:0] pin_sync,
    output logic [DW-1:0]   bus_rdata,
    output port_cfg_t       cfg
);
    port_cfg_t cfg_q;
    reg_sel_e  sel;

    assign sel = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            cfg_q <= '0;
        end else if (manual_rst) begin
            cfg_q.dat <= '0;
            cfg_q.pu  <= '0;
            cfg_q.od  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_DIR: cfg_q.dir <= bus_wdata[NPIN-1:0];
                SEL_DAT: cfg_q.dat <= bus_wdata[NPIN-1:0];
                SEL_PU:  cfg_q.pu  <= bus_wdata[NPIN-1:0];
                SEL_OD:  cfg_q.od  <= bus_wdata[NPIN-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_DIR: bus_rdata = DIR_READ_FILL;
                SEL_DAT: bus_rdata = zext(cfg_q.dat);
                SEL_PIN: bus_rdata = zext(pin_sync);
                SEL_PU:  bus_rdata = zext(cfg_q.pu);
                SEL_OD:  bus_rdata = zext(cfg_q.od);
                default: bus_rdata = '0;
            endcase
        end
    end

    assign cfg = cfg_q;

    assert_dir_kept_manual_R4: assert property (@(posedge clk) disable iff (rst)
        (manual_rst && !hw_stby) |=> cfg_q.dir == $past(cfg_q.dir));
    assert_dir_clear_hw_R4: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> cfg_q.dir == '0);
    assert_hw_blocks_write_R11: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> cfg_q == '0);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel != SEL_DIR) |-> bus_rdata[DW-1:NPIN] == '0);
endmodule

// File: rtl/gpio4_pin_ctl.sv
module gpio4_pin_ctl
    import gpio4_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hw_stby,
    input  logic     sw_stby,
    input  logic     addr_mode,
    input  logic     out_hold,
    input  logic     addr_now,
    input  logic     addr_held,
    input  logic     dir,
    input  logic     dat,
    input  logic     pu_en,
    input  logic     od_en,
    output pad_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        if (hw_stby) begin
            ctl = '0;
        end else if (addr_mode) begin
            if (sw_stby) begin
                ctl.oe  = out_hold;
                ctl.out = out_hold & addr_held;
            end else begin
                ctl.oe  = 1'b1;
                ctl.out = addr_now;
            end
        end else if (dir) begin
            ctl.out = dat;
            ctl.oe  = od_en ? ~dat : 1'b1;
        end else begin
            ctl.pu = pu_en;
        end
    end

    assert_addr_drive_R7: assert property (@(posedge clk) disable iff (rst)
        (addr_mode && !sw_stby && !hw_stby) |-> (ctl.oe && ctl.out == addr_now && !ctl.pu));
    assert_pu_only_input_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.pu |-> (!ctl.oe && !dir && !addr_mode));
    assert_od_release_R10: assert property (@(posedge clk) disable iff (rst)
        (!hw_stby && !addr_mode && dir && od_en && dat) |-> !ctl.oe);
    assert_hw_release_R11: assert property (@(posedge clk) disable iff (rst)
        hw_stby |-> (ctl == '0));
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
    import gpio4_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            manual_rst,
    input  logic            hw_stby,
    input  logic            sw_stby,
    input  logic            out_hold,
    input  logic [2:0]      op_mode,
    input  logic [NPIN-1:0] addr_in,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_pu
);
    port_cfg_t       cfg;
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] addr_hold_q;
    logic            amode;

    assign amode = is_addr_mode(op_mode);

    always_ff @(posedge clk) begin
        if (rst)
            addr_hold_q <= '0;
        else if (!sw_stby)
            addr_hold_q <= addr_in;
    end

    gpio4_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio4_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .manual_rst (manual_rst),
        .hw_stby    (hw_stby),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .pin_sync   (pin_sync),
        .bus_rdata  (bus_rdata),
        .cfg        (cfg)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pad_ctl_t ctl;
        gpio4_pin_ctl u_ctl (
            .clk       (clk),
            .rst       (rst),
            .hw_stby   (hw_stby),
            .sw_stby   (sw_stby),
            .addr_mode (amode),
            .out_hold  (out_hold),
            .addr_now  (addr_in[i]),
            .addr_held (addr_hold_q[i]),
            .dir       (cfg.dir[i]),
            .dat       (cfg.dat[i]),
            .pu_en     (cfg.pu[i]),
            .od_en     (cfg.od[i]),
            .ctl       (ctl)
        );
        assign pad_oe[i]  = ctl.oe;
        assign pad_out[i] = ctl.out;
        assign pad_pu[i]  = ctl.pu;
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_stby && $past(sw_stby) && amode && $past(amode) && out_hold
         && $past(out_hold) && !hw_stby && !$past(hw_stby)) |-> $stable(pad_out));
    assert_float_no_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_stby && amode && !out_hold) |-> pad_oe == '0);
endmodule

// File: tb/tb_gpio4_port.sv
`timescale 1ns/1ps
module tb_gpio4_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1, manual_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0, out_hold = 1'b0;
    logic [2:0] op_mode = 3'd1;
    logic [3:0] addr_in = 4'h0, pin_in = 4'h0;
    logic [15:0] bus_addr = 16'h0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h0;
    logic [7:0] bus_rdata;
    logic [3:0] pad_oe, pad_out, pad_pu;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [3:0] m_dir, m_dat, m_pu, m_od, m_s1, m_s2, m_hold;

    always #2.5 clk = ~clk;

    gpio4_port dut (
        .clk(clk), .rst(rst), .manual_rst(manual_rst), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .out_hold(out_hold), .op_mode(op_mode), .addr_in(addr_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu)
    );

    task automatic model_step();
        if (rst) begin
            m_dir = 0; m_dat = 0; m_pu = 0; m_od = 0; m_s1 = 0; m_s2 = 0; m_hold = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (!sw_stby) m_hold = addr_in;
            if (hw_stby) begin
                m_dir = 0; m_dat = 0; m_pu = 0; m_od = 0;
            end else if (manual_rst) begin
                m_dat = 0; m_pu = 0; m_od = 0;
            end else if (bus_wr) begin
                if (bus_addr == 16'hFEB9) m_dir = bus_wdata[3:0];
                if (bus_addr == 16'hFF69) m_dat = bus_wdata[3:0];
                if (bus_addr == 16'hFF70) m_pu  = bus_wdata[3:0];
                if (bus_addr == 16'hFF77) m_od  = bus_wdata[3:0];
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [3:0] e_oe, e_out, e_pu;
        logic [7:0] e_rd;
        bit amode;
        amode = (op_mode == 3'd4) || (op_mode == 3'd5);
        e_oe = 0; e_out = 0; e_pu = 0;
        for (int i = 0; i < 4; i++) begin
            if (hw_stby) begin
                // all released
            end else if (amode) begin
                if (sw_stby) begin
                    e_oe[i] = out_hold;
                    e_out[i] = out_hold ? m_hold[i] : 1'b0;
                end else begin
                    e_oe[i] = 1'b1;
                    e_out[i] = addr_in[i];
                end
            end else if (m_dir[i]) begin
                e_out[i] = m_dat[i];
                e_oe[i] = !(m_od[i] && m_dat[i]);
            end else begin
                e_pu[i] = m_pu[i];
            end
        end
        e_rd = 8'h00;
        if (bus_rd) begin
            if (bus_addr == 16'hFEB9) e_rd = 8'hFF;
            else if (bus_addr == 16'hFF69) e_rd = {4'h0, m_dat};
            else if (bus_addr == 16'hFF59) e_rd = {4'h0, m_s2};
            else if (bus_addr == 16'hFF70) e_rd = {4'h0, m_pu};
            else if (bus_addr == 16'hFF77) e_rd = {4'h0, m_od};
        end
        tests++;
        if (pad_oe !== e_oe || pad_out !== e_out || pad_pu !== e_pu || bus_rdata !== e_rd) begin
            fails++;
            $display("FAIL %s: oe/out/pu/rdata actual %h/%h/%h/%h expected %h/%h/%h/%h",
                     tag, pad_oe, pad_out, pad_pu, bus_rdata, e_oe, e_out, e_pu, e_rd);
        end
    endtask

    task automatic cyc(input string tag);
        #1;
        compare(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc(tag);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        bus_rd = 1; bus_addr = a;
        cyc(tag);
        bus_rd = 0;
    endtask

    initial begin
        m_dir = 0; m_dat = 0; m_pu = 0; m_od = 0; m_s1 = 0; m_s2 = 0; m_hold = 0;
        @(negedge clk);
        // R1: reset state
        cyc("R1"); cyc("R1");
        rst = 0;
        cyc("R1");
        rd(16'hFF69, "R1"); rd(16'hFF70, "R1"); rd(16'hFF77, "R1");

        // R12/R3/R5: direction and data writes
        wr(16'hFF69, 8'hF5, "R5");
        wr(16'hFEB9, 8'hFA, "R12");
        cyc("R3");
        rd(16'hFF69, "R5");
        rd(16'hFEB9, "R2");
        rd(16'h1234, "R2");
        wr(16'hFF69, 8'h0A, "R3");
        cyc("R3");

        // R9: pull-ups on inputs only
        wr(16'hFF70, 8'hFF, "R9");
        rd(16'hFF70, "R5");
        cyc("R9");

        // R10: open drain
        wr(16'hFF77, 8'h0F, "R10");
        wr(16'hFEB9, 8'h0F, "R10");
        wr(16'hFF69, 8'h05, "R10");
        rd(16'hFF77, "R5");
        wr(16'hFF69, 8'h0A, "R10");
        cyc("R10");

        // R6: pin readback two edges late, writes ignored
        pin_in = 4'h9; cyc("R6");
        rd(16'hFF59, "R6");
        rd(16'hFF59, "R6");
        pin_in = 4'h6;
        rd(16'hFF59, "R6"); rd(16'hFF59, "R6"); rd(16'hFF59, "R6");
        wr(16'hFF59, 8'hFF, "R6");
        rd(16'hFF69, "R6"); rd(16'hFF70, "R6"); rd(16'hFF77, "R6");
        cyc("R6");

        // R4: manual reset keeps direction, clears others; write same cycle ignored
        wr(16'hFF77, 8'h00, "R4");
        wr(16'hFEB9, 8'h03, "R4");
        manual_rst = 1;
        wr(16'hFEB9, 8'h0C, "R4");
        manual_rst = 0;
        cyc("R4");
        rd(16'hFF69, "R4"); rd(16'hFF70, "R4");
        wr(16'hFF69, 8'h03, "R4");
        sw_stby = 1; cyc("R4"); cyc("R4"); sw_stby = 0;
        cyc("R4");

        // R7: address modes override direction
        addr_in = 4'hB;
        op_mode = 3'd4; cyc("R7"); addr_in = 4'h4; cyc("R7");
        op_mode = 3'd5; addr_in = 4'hD; cyc("R7"); cyc("R7");
        op_mode = 3'd7; cyc("R3");
        op_mode = 3'd2; cyc("R3");

        // R8: software standby in address mode
        op_mode = 3'd4; addr_in = 4'hA; cyc("R8");
        out_hold = 1; sw_stby = 1; cyc("R8");
        addr_in = 4'h5; cyc("R8"); cyc("R8");
        out_hold = 0; cyc("R8"); cyc("R8");
        sw_stby = 0; cyc("R8"); cyc("R8");
        addr_in = 4'h3; cyc("R8");
        out_hold = 1; sw_stby = 1; addr_in = 4'hC; cyc("R8"); cyc("R8");
        sw_stby = 0; out_hold = 0;
        op_mode = 3'd1; cyc("R3");

        // R11/R4: hardware standby
        wr(16'hFF70, 8'h0C, "R9");
        cyc("R9");
        hw_stby = 1;
        wr(16'hFEB9, 8'h0F, "R11");
        wr(16'hFF69, 8'h0F, "R11");
        op_mode = 3'd4; cyc("R11"); op_mode = 3'd1;
        hw_stby = 0;
        cyc("R4");
        rd(16'hFF69, "R11"); rd(16'hFF70, "R11");

        // R1: power-on reset after activity
        wr(16'hFEB9, 8'h0F, "R1");
        wr(16'hFF69, 8'h0F, "R1");
        rst = 1; cyc("R1"); rst = 0;
        cyc("R1"); rd(16'hFF69, "R1"); rd(16'hFF59, "R1");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule